// File: doc/BRIEF.md
# Thirty-Two Line Interrupt Aggregator

This block gathers up to thirty-two interrupt request wires into one processor interrupt. Each wire first passes through a polarity stage. It is then treated either as a level that the block follows directly or as an edge that the block latches. The result is gated by a software enable and made visible in a read-only status word. The processor interrupt is the OR of that status word. Software finds the lowest set status bit, services that line, and moves upward.

Lines 0 to 19 carry the four interrupt wires of each add-in slot. Line 31 carries the cascade request from a secondary legacy controller. Lines 20 to 30 are never wired, so they can never be enabled. A latched edge is dismissed by writing a 1 to the line's bit in the dismiss register and then writing 0. A separate write-only register produces a one-cycle system restart pulse, but only when it receives one particular key value.

Software reaches the block through a small word-addressed register port. A request is accepted on any clock edge where `bus_valid_i` is high. `bus_ready_o` is always high, so the block never applies back-pressure. A read returns its data with `rsp_valid_o` exactly one cycle after it is accepted. The response has no ready signal, so the requester must accept it in that cycle.

Top module: `irqagg_top`

## Requirements
- R1: After reset the enable register reads 0, the mode register reads 0 (every line level-sensitive), the polarity register reads 0x80000000, the dismiss register reads 0, and `irq_o` is low.
- R2: Register word 0 is the enable register, where a 1 enables a line. Bits 20 to 30 cannot be set and always read 0. A line whose enable bit is 0 never shows in the status word.
- R3: Register word 2 is the polarity register. A 1 makes a line active-high and a 0 makes it active-low. The raw wire is inverted when its bit is 0.
- R4: In level mode (mode register word 1, bit 0), a status bit equals the enabled, conditioned wire. It follows a change of the wire one clock edge later.
- R5: In edge mode (mode bit 1), a rise of the conditioned wire latches a pending bit on the same edge that samples it. The latch happens whether or not the line is enabled. The bit stays set after the wire falls, and a wire held active does not set it again.
- R6: Register word 3 is the dismiss register. While a line's dismiss bit is 1, its pending bit is cleared and held clear. After the bit is written back to 0, the next rise latches again.
- R7: Register word 4 is the read-only status word. Bits 20 to 30 always read 0, bit 31 is the cascade line, and writes to it have no effect.
- R8: `irq_o` is high exactly when the status word is non-zero.
- R9: Writing exactly 0x0000DEAD to register word 5 drives `sys_restart_o` high for one cycle, starting on the edge after the write. Any other value, or that value written to another word, produces no pulse. Word 5 reads 0.
- R10: `bus_ready_o` is always 1. A read accepted on one edge gives `rsp_valid_o` high and its data on `rsp_rdata_o` after the next edge. Words 6 and 7 read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low synchronous reset |
| line_raw_i | input | 32 | Raw interrupt wires, one per line |
| bus_valid_i | input | 1 | Register request valid |
| bus_ready_o | output | 1 | Register request ready (always 1) |
| bus_write_i | input | 1 | 1 for write, 0 for read |
| bus_addr_i | input | 3 | Register word index |
| bus_wdata_i | input | 32 | Write data |
| rsp_valid_o | output | 1 | Read data valid |
| rsp_rdata_o | output | 32 | Read data |
| irq_o | output | 1 | Combined interrupt to the processor |
| sys_restart_o | output | 1 | One-cycle system restart request |

## Verification
The bench walks a single active wire across all thirty-two positions in level mode and in edge mode, under both polarities. A design that let the unwired lines 20 to 30 through, or that inverted polarity the wrong way, fails on the exact bit concerned. The bench holds an edge-mode wire high across a full dismiss sequence. A design that latched on level instead of on rise would show the line again at once. It also latches an edge while the line is disabled and expects the bit to appear when the line is enabled, which catches latching gated by the enable. The restart key is tried with an off-by-one value, with a wider value, and at the wrong word; a loose comparison would pulse on at least one of these.

// File: rtl/irqagg_pkg.sv
package irqagg_pkg;

  localparam int unsigned REG_AW = 3;

  typedef enum logic [REG_AW-1:0] {
    RA_ENABLE   = 3'd0,
    RA_MODE     = 3'd1,
    RA_POLARITY = 3'd2,
    RA_DISMISS  = 3'd3,
    RA_STATUS   = 3'd4,
    RA_RESTART  = 3'd5
  } reg_addr_e;

endpackage

// File: rtl/irqagg_line.sv
// One interrupt line: polarity conditioning, level follow or edge latch.
module irqagg_line (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic raw_i,
  input  logic active_high_i,
  input  logic edge_mode_i,
  input  logic enable_i,
  input  logic dismiss_i,
  output logic req_o
);

  logic cond_in;
  logic cond_q;
  logic pend_q;
  logic rise;

  assign cond_in = raw_i ^ ~active_high_i;
  assign rise    = cond_in & ~cond_q;

  always_ff @(posedge clk_i) begin
    if (!rst_ni) begin
      cond_q <= 1'b0;
      pend_q <= 1'b0;
    end else begin
      cond_q <= cond_in;
      pend_q <= edge_mode_i & ~dismiss_i & (pend_q | rise);
    end
  end

  assign req_o = enable_i & (edge_mode_i ? pend_q : cond_q);

endmodule

// File: rtl/irqagg_regs.sv
// Register file and single-cycle request port.
module irqagg_regs
  import irqagg_pkg::*;
#(
  parameter int unsigned           NUM_LINES    = 32,
  parameter int unsigned           CASCADE_IDX  = 31,
  parameter logic [NUM_LINES-1:0]  LINE_PRESENT = 32'h800F_FFFF
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 bus_valid_i,
  input  logic                 bus_write_i,
  input  logic [REG_AW-1:0]    bus_addr_i,
  input  logic [NUM_LINES-1:0] bus_wdata_i,
  input  logic [NUM_LINES-1:0] status_i,
  output logic [NUM_LINES-1:0] enable_o,
  output logic [NUM_LINES-1:0] mode_o,
  output logic [NUM_LINES-1:0] polarity_o,
  output logic [NUM_LINES-1:0] dismiss_o,
  output logic                 wr_restart_o,
  output logic                 rsp_valid_o,
  output logic [NUM_LINES-1:0] rsp_rdata_o
);

  localparam logic [NUM_LINES-1:0] POL_RESET = NUM_LINES'(1) << CASCADE_IDX;

  logic                 wr_fire;
  logic                 rd_fire;
  logic [NUM_LINES-1:0] en_q;
  logic [NUM_LINES-1:0] mode_q;
  logic [NUM_LINES-1:0] pol_q;
  logic [NUM_LINES-1:0] dis_q;
  logic                 rv_q;
  logic [NUM_LINES-1:0] rd_q;
  logic [NUM_LINES-1:0] rd_mux;

  assign wr_fire = bus_valid_i & bus_write_i;
  assign rd_fire = bus_valid_i & ~bus_write_i;
  assign wr_restart_o = wr_fire & (bus_addr_i == RA_RESTART);

  always_comb begin
    rd_mux = '0;
    case (bus_addr_i)
      RA_ENABLE:   rd_mux = en_q;
      RA_MODE:     rd_mux = mode_q;
      RA_POLARITY: rd_mux = pol_q;
      RA_DISMISS:  rd_mux = dis_q;
      RA_STATUS:   rd_mux = status_i;
      default:     rd_mux = '0;
    endcase
  end

  always_ff @(posedge clk_i) begin
    if (!rst_ni) begin
      en_q   <= '0;
      mode_q <= '0;
      pol_q  <= POL_RESET;
      dis_q  <= '0;
      rv_q   <= 1'b0;
      rd_q   <= '0;
    end else begin
      rv_q <= rd_fire;
      if (rd_fire) rd_q <= rd_mux;
      if (wr_fire) begin
        case (bus_addr_i)
          RA_ENABLE:   en_q   <= bus_wdata_i & LINE_PRESENT;
          RA_MODE:     mode_q <= bus_wdata_i;
          RA_POLARITY: pol_q  <= bus_wdata_i;
          RA_DISMISS:  dis_q  <= bus_wdata_i;
          default:     ;
        endcase
      end
    end
  end

  assign enable_o    = en_q;
  assign mode_o      = mode_q;
  assign polarity_o  = pol_q;
  assign dismiss_o   = dis_q;
  assign rsp_valid_o = rv_q;
  assign rsp_rdata_o = rd_q;

endmodule

// File: rtl/irqagg_restart.sv
// Keyed restart pulse generator.
module irqagg_restart #(
  parameter int unsigned          DATA_W = 32,
  parameter logic [DATA_W-1:0]    KEY    = 32'h0000_DEAD
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic              pulse_o
);

  logic pulse_q;

  always_ff @(posedge clk_i) begin
    if (!rst_ni) pulse_q <= 1'b0;
    else         pulse_q <= wr_i & (wdata_i == KEY);
  end

  assign pulse_o = pulse_q;

endmodule

// File: rtl/irqagg_top.sv
module irqagg_top
  import irqagg_pkg::*;
#(
  parameter int unsigned          NUM_LINES    = 32,
  parameter int unsigned          CASCADE_IDX  = 31,
  parameter logic [NUM_LINES-1:0] LINE_PRESENT = 32'h800F_FFFF,
  parameter logic [NUM_LINES-1:0] RESTART_KEY  = 32'h0000_DEAD
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic [NUM_LINES-1:0] line_raw_i,
  input  logic                 bus_valid_i,
  output logic                 bus_ready_o,
  input  logic                 bus_write_i,
  input  logic [REG_AW-1:0]    bus_addr_i,
  input  logic [NUM_LINES-1:0] bus_wdata_i,
  output logic                 rsp_valid_o,
  output logic [NUM_LINES-1:0] rsp_rdata_o,
  output logic                 irq_o,
  output logic                 sys_restart_o
);

  logic [NUM_LINES-1:0] enable_w;
  logic [NUM_LINES-1:0] mode_w;
  logic [NUM_LINES-1:0] pol_w;
  logic [NUM_LINES-1:0] dismiss_w;
  logic [NUM_LINES-1:0] status_w;
  logic                 wr_restart;

  assign bus_ready_o = 1'b1;

  irqagg_regs #(
    .NUM_LINES   (NUM_LINES),
    .CASCADE_IDX (CASCADE_IDX),
    .LINE_PRESENT(LINE_PRESENT)
  ) u_regs (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .bus_valid_i  (bus_valid_i),
    .bus_write_i  (bus_write_i),
    .bus_addr_i   (bus_addr_i),
    .bus_wdata_i  (bus_wdata_i),
    .status_i     (status_w),
    .enable_o     (enable_w),
    .mode_o       (mode_w),
    .polarity_o   (pol_w),
    .dismiss_o    (dismiss_w),
    .wr_restart_o (wr_restart),
    .rsp_valid_o  (rsp_valid_o),
    .rsp_rdata_o  (rsp_rdata_o)
  );

  for (genvar gi = 0; gi < NUM_LINES; gi++) begin : g_line
    irqagg_line u_line (
      .clk_i         (clk_i),
      .rst_ni        (rst_ni),
      .raw_i         (line_raw_i[gi]),
      .active_high_i (pol_w[gi]),
      .edge_mode_i   (mode_w[gi]),
      .enable_i      (enable_w[gi] & LINE_PRESENT[gi]),
      .dismiss_i     (dismiss_w[gi]),
      .req_o         (status_w[gi])
    );
  end

  assign irq_o = |status_w;

  irqagg_restart #(
    .DATA_W(NUM_LINES),
    .KEY   (RESTART_KEY)
  ) u_restart (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .wr_i    (wr_restart),
    .wdata_i (bus_wdata_i),
    .pulse_o (sys_restart_o)
  );

endmodule

// File: rtl/irqagg_checker.sv
module irqagg_checker
  import irqagg_pkg::*;
#(
  parameter int unsigned          NUM_LINES    = 32,
  parameter logic [NUM_LINES-1:0] LINE_PRESENT = 32'h800F_FFFF,
  parameter logic [NUM_LINES-1:0] RESTART_KEY  = 32'h0000_DEAD
) (
  input logic                 clk_i,
  input logic                 rst_ni,
  input logic                 bus_valid_i,
  input logic                 bus_write_i,
  input logic [REG_AW-1:0]    bus_addr_i,
  input logic [NUM_LINES-1:0] bus_wdata_i,
  input logic                 rsp_valid_o,
  input logic [NUM_LINES-1:0] rsp_rdata_o,
  input logic                 irq_o,
  input logic                 sys_restart_o,
  input logic [NUM_LINES-1:0] enable_w,
  input logic [NUM_LINES-1:0] mode_w,
  input logic [NUM_LINES-1:0] dismiss_w,
  input logic [NUM_LINES-1:0] status_w
);

  // R7: status reads never show the unwired lines
  p_resv_zero_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $past(bus_valid_i && !bus_write_i && bus_addr_i == RA_STATUS)
      |-> ((rsp_rdata_o & ~LINE_PRESENT) == '0));

  // R9: pulse lasts one cycle unless a new restart write arrives
  p_pulse_once_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sys_restart_o && !(bus_valid_i && bus_write_i && bus_addr_i == RA_RESTART))
      |=> !sys_restart_o);

  // R9: pulse only after a keyed write to the restart word
  p_pulse_cause_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sys_restart_o |-> $past(bus_valid_i && bus_write_i &&
                            bus_addr_i == RA_RESTART && bus_wdata_i == RESTART_KEY));

  // R10: a response follows an accepted read
  p_rsp_after_read_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rsp_valid_o |-> $past(bus_valid_i && !bus_write_i));

  // R2: nothing enabled means no interrupt
  p_no_irq_disabled_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (enable_w == '0) |-> !irq_o);

  // R6: a held dismiss keeps an edge line clear
  p_dismiss_holds_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_w[0] && dismiss_w[0] && $past(dismiss_w[0]) && $past(mode_w[0]))
      |-> !status_w[0]);

endmodule

bind irqagg_top irqagg_checker #(
  .NUM_LINES   (NUM_LINES),
  .LINE_PRESENT(LINE_PRESENT),
  .RESTART_KEY (RESTART_KEY)
) u_irqagg_checker (
  .clk_i         (clk_i),
  .rst_ni        (rst_ni),
  .bus_valid_i   (bus_valid_i),
  .bus_write_i   (bus_write_i),
  .bus_addr_i    (bus_addr_i),
  .bus_wdata_i   (bus_wdata_i),
  .rsp_valid_o   (rsp_valid_o),
  .rsp_rdata_o   (rsp_rdata_o),
  .irq_o         (irq_o),
  .sys_restart_o (sys_restart_o),
  .enable_w      (enable_w),
  .mode_w        (mode_w),
  .dismiss_w     (dismiss_w),
  .status_w      (status_w)
);

// File: tb/test_irqagg_top.sv
`timescale 1ns/1ps
module test_irqagg_top;

  localparam logic [31:0] PRESENT = 32'h800F_FFFF;
  localparam logic [2:0] A_EN = 3'd0, A_MODE = 3'd1, A_POL = 3'd2,
                         A_DIS = 3'd3, A_STAT = 3'd4, A_RST = 3'd5;

  logic        clk = 1'b0;
  logic        rst_n;
  logic [31:0] raw;
  logic        bvalid, bready, bwrite;
  logic [2:0]  baddr;
  logic [31:0] bwdata;
  logic        rvalid;
  logic [31:0] rdata;
  logic        irq, restart;

  int checks = 0;
  int fails = 0;
  logic pulse_seen;
  logic [31:0] rd;

  always #5 clk = ~clk;

  irqagg_top i_irqagg_top (
    .clk_i(clk), .rst_ni(rst_n), .line_raw_i(raw),
    .bus_valid_i(bvalid), .bus_ready_o(bready), .bus_write_i(bwrite),
    .bus_addr_i(baddr), .bus_wdata_i(bwdata),
    .rsp_valid_o(rvalid), .rsp_rdata_o(rdata),
    .irq_o(irq), .sys_restart_o(restart)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [31:0] d);
    @(negedge clk);
    bvalid = 1'b1; bwrite = 1'b1; baddr = a; bwdata = d;
    @(negedge clk);
    pulse_seen = restart;
    bvalid = 1'b0; bwrite = 1'b0;
  endtask

  task automatic rdreg(input logic [2:0] a, output logic [31:0] d);
    @(negedge clk);
    bvalid = 1'b1; bwrite = 1'b0; baddr = a;
    @(negedge clk);
    d = rdata;
    chk("R10 rsp_valid", {31'd0, rvalid}, 32'd1);
    bvalid = 1'b0;
  endtask

  initial begin
    #1ms;
    fails++; checks++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    rst_n = 1'b0; raw = '0; bvalid = 1'b0; bwrite = 1'b0; baddr = '0; bwdata = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R1 reset state
    rdreg(A_EN, rd);   chk("R1 enable", rd, 32'h0);
    rdreg(A_MODE, rd); chk("R1 mode", rd, 32'h0);
    rdreg(A_POL, rd);  chk("R1 polarity", rd, 32'h8000_0000);
    rdreg(A_DIS, rd);  chk("R1 dismiss", rd, 32'h0);
    chk("R1 irq", {31'd0, irq}, 32'd0);
    chk("R10 ready", {31'd0, bready}, 32'd1);

    // R2 unwired lines cannot be enabled
    wr(A_EN, 32'hFFFF_FFFF);
    rdreg(A_EN, rd); chk("R2 enable readback", rd, PRESENT);

    // R3 default polarity: line 31 active-high, rest active-low
    raw = 32'h0; @(negedge clk);
    rdreg(A_STAT, rd); chk("R3 default pol raw=0", rd, 32'h000F_FFFF);
    chk("R8 irq on", {31'd0, irq}, 32'd1);
    raw = 32'h8000_0000; @(negedge clk);
    rdreg(A_STAT, rd); chk("R7 cascade bit", rd, 32'h800F_FFFF);
    raw = 32'h7FFF_FFFF; @(negedge clk);
    rdreg(A_STAT, rd); chk("R3 all inactive", rd, 32'h0);
    chk("R8 irq off", {31'd0, irq}, 32'd0);

    // R4 level sweep, active-high
    wr(A_POL, 32'hFFFF_FFFF);
    for (int i = 0; i < 32; i++) begin
      raw = 32'h1 << i;
      @(negedge clk);
      chk("R4 level high irq", {31'd0, irq}, {31'd0, |((32'h1 << i) & PRESENT)});
      rdreg(A_STAT, rd); chk("R4 level high status", rd, (32'h1 << i) & PRESENT);
    end
    raw = 32'h0; @(negedge clk);
    rdreg(A_STAT, rd); chk("R4 level release", rd, 32'h0);

    // R3 level sweep, active-low
    wr(A_POL, 32'h0);
    for (int i = 0; i < 32; i++) begin
      raw = ~(32'h1 << i);
      @(negedge clk);
      rdreg(A_STAT, rd); chk("R3 level low status", rd, (32'h1 << i) & PRESENT);
    end

    // R2 partial enable
    raw = 32'h0; wr(A_EN, 32'h0000_AAAA); @(negedge clk);
    rdreg(A_STAT, rd); chk("R2 partial enable", rd, 32'h0000_AAAA);

    // R5/R6 edge sweep, active-high
    wr(A_EN, 32'hFFFF_FFFF);
    wr(A_POL, 32'hFFFF_FFFF);
    raw = 32'h0;
    wr(A_MODE, 32'hFFFF_FFFF);
    wr(A_DIS, 32'hFFFF_FFFF); wr(A_DIS, 32'h0);
    rdreg(A_STAT, rd); chk("R6 clean start", rd, 32'h0);
    for (int i = 0; i < 32; i++) begin
      raw = 32'h1 << i; @(negedge clk);
      raw = 32'h0;      @(negedge clk);
      rdreg(A_STAT, rd); chk("R5 edge latched", rd, (32'h1 << i) & PRESENT);
      chk("R8 irq edge", {31'd0, irq}, {31'd0, |((32'h1 << i) & PRESENT)});
      wr(A_DIS, 32'h1 << i);
      rdreg(A_STAT, rd); chk("R6 dismiss clears", rd, 32'h0);
      wr(A_DIS, 32'h0);
      rdreg(A_STAT, rd); chk("R6 stays clear", rd, 32'h0);
    end

    // R5 held wire does not retrigger; R6 rearm
    raw = 32'h8; @(negedge clk);
    wr(A_DIS, 32'h8); wr(A_DIS, 32'h0);
    rdreg(A_STAT, rd); chk("R5 held no retrigger", rd, 32'h0);
    raw = 32'h0; @(negedge clk);
    raw = 32'h8; @(negedge clk);
    rdreg(A_STAT, rd); chk("R6 rearmed", rd, 32'h8);
    raw = 32'h0; wr(A_DIS, 32'h8); wr(A_DIS, 32'h0);

    // R5 latch while disabled
    wr(A_EN, 32'h0);
    raw = 32'h20; @(negedge clk); raw = 32'h0; @(negedge clk);
    chk("R2 disabled no irq", {31'd0, irq}, 32'd0);
    wr(A_EN, 32'hFFFF_FFFF);
    rdreg(A_STAT, rd); chk("R5 latched while disabled", rd, 32'h20);
    wr(A_DIS, 32'h20); wr(A_DIS, 32'h0);

    // R3/R5 active-low edge
    raw = 32'hFFFF_FFFF;
    wr(A_POL, 32'h0);
    wr(A_DIS, 32'hFFFF_FFFF); wr(A_DIS, 32'h0);
    raw = ~32'h40; @(negedge clk); raw = 32'hFFFF_FFFF; @(negedge clk);
    rdreg(A_STAT, rd); chk("R3 falling edge latched", rd, 32'h40);

    // R7 status write ignored
    wr(A_STAT, 32'h0);
    rdreg(A_STAT, rd); chk("R7 status write ignored", rd, 32'h40);

    // R9 restart key
    wr(A_RST, 32'h0000_DEAD);
    chk("R9 key pulse", {31'd0, pulse_seen}, 32'd1);
    @(negedge clk);
    chk("R9 pulse one cycle", {31'd0, restart}, 32'd0);
    wr(A_RST, 32'h0000_DEAE);
    chk("R9 wrong key", {31'd0, pulse_seen}, 32'd0);
    wr(A_RST, 32'h0001_DEAD);
    chk("R9 wide key", {31'd0, pulse_seen}, 32'd0);
    wr(A_MODE, 32'h0000_DEAD);
    chk("R9 wrong word", {31'd0, pulse_seen}, 32'd0);
    rdreg(A_RST, rd); chk("R9 restart reads zero", rd, 32'h0);
    rdreg(3'd7, rd);  chk("R10 unmapped zero", rd, 32'h0);

    $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

endmodule